// File: doc/BRIEF.md
# Multi-Queue Task Pointer Dispatcher

This block is the scheduling front end of a reconfigurable data-processing engine. Software places task pointers into a set of per-context queues. The dispatcher hands them to the engine one at a time. Each queue is a hardware thread context. A pointer from a queue is launched only when that context has no task running. The number of queues therefore sets how many tasks the engine runs at once.

Every cycle the dispatcher finds the eligible queues. A queue is eligible when it is enabled, not empty and idle. One of them is chosen round-robin, its head pointer is popped, and the launch is presented on a registered launch port as a one-cycle pulse. The pulse carries the queue index as the thread identifier and the pointer itself. The engine ends a thread by pulsing the done bit of that thread. A run-time count selects how many queues, taken from index 0 upward, may launch. A queue above the count keeps its pointers and still accepts new ones.

Top module: `task_ptr_dispatch`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, launch_valid_o is 0 and every push_ready_o bit is 1.
- R2: push_ready_o[q] is 0 exactly when queue q holds DEPTH (8) pointers. A push offered while it is 0 is dropped and leaves that queue's contents unchanged.
- R3: Pointers from one queue are launched in the order in which they were accepted.
- R4: Each accepted pointer is launched exactly once. The launch is a single cycle with launch_valid_o = 1, launch_id_o = the queue index and launch_ptr_o = the pointer.
- R5: After a launch from queue q, no further launch from q occurs until done_i[q] has been sampled high.
- R6: Latency is fixed. A queue that is eligible on clock edge e and wins arbitration shows its launch in the cycle after e. A pointer pushed at edge e, or a done_i sampled at edge e, allows the next launch from that queue one cycle after edge e+1 at the earliest.
- R7: When several queues are eligible, the winner is the first eligible index after the previously launched index, searching upward and wrapping around. After reset the search starts at index 0.
- R8: Queue q may launch only if q < q_en_cnt_i as sampled on the arbitration edge. A disabled queue keeps its pointers and accepts pushes, and launches them in order once it is enabled.
- R9: A done_i[q] pulse while queue q has no task outstanding has no effect.
- R10: Tasks from different queues are outstanding at the same time. A queue's launch never waits for another queue's done. At most one launch occurs per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| q_en_cnt_i | input | $clog2(NUM_Q+1) | Number of enabled queues, counted from index 0 |
| push_valid_i | input | NUM_Q | Push request for each queue |
| push_ptr_i | input | NUM_Q*PTR_W | Pointer for each queue; queue q uses bits [q*PTR_W +: PTR_W] |
| push_ready_o | output | NUM_Q | Queue is not full |
| done_i | input | NUM_Q | Thread completion pulse for each queue |
| launch_valid_o | output | 1 | Launch pulse to the engine |
| launch_id_o | output | $clog2(NUM_Q) | Thread identifier (queue index) of the launch |
| launch_ptr_o | output | PTR_W | Task pointer being launched |

## Verification
The bench drives the block with several input patterns and compares every cycle against a cycle-level model of the requirements.
- A single queue filled past its depth while disabled separates the full flag, the overflow drop and retention from the in-order drain that follows enabling.
- All four queues loaded with no done pulses separates round-robin order from lowest-index priority. It also shows that contexts run concurrently.
- Done pulses aimed at idle queues expose any busy tracking that a stray done disturbs.
- Long random runs mix pushes, done pulses and changes of the enable count, and so reach the simultaneous push, pop and done cases.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  localparam int unsigned NUM_Q_DEF = 4;
  localparam int unsigned DEPTH_DEF = 8;
  localparam int unsigned PTR_W_DEF = 32;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tpd_fifo.sv
module tpd_fifo #(
  parameter int unsigned DEPTH = tpd_pkg::DEPTH_DEF,
  parameter int unsigned W     = tpd_pkg::PTR_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned AW = tpd_pkg::idx_w(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/tpd_rr_arb.sv
module tpd_rr_arb #(
  parameter  int unsigned N  = tpd_pkg::NUM_Q_DEF,
  localparam int unsigned IW = tpd_pkg::idx_w(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] last_q;

  // search starts one past the last winner, wrapping
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = 1; k <= int'(N); k++) begin
      int j;
      j = int'(last_q) + k;
      if (j >= int'(N)) j = j - int'(N);
      if (!any_o && req_i[j]) begin
        any_o = 1'b1;
        idx_o = IW'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= IW'(N - 1);
    else if (any_o) last_q <= idx_o;
  end
endmodule

// File: rtl/task_ptr_dispatch.sv
module task_ptr_dispatch #(
  parameter  int unsigned NUM_Q = tpd_pkg::NUM_Q_DEF,
  parameter  int unsigned DEPTH = tpd_pkg::DEPTH_DEF,
  parameter  int unsigned PTR_W = tpd_pkg::PTR_W_DEF,
  localparam int unsigned ID_W  = tpd_pkg::idx_w(NUM_Q),
  localparam int unsigned EN_W  = $clog2(NUM_Q + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [EN_W-1:0]        q_en_cnt_i,
  input  logic [NUM_Q-1:0]       push_valid_i,
  input  logic [NUM_Q*PTR_W-1:0] push_ptr_i,
  output logic [NUM_Q-1:0]       push_ready_o,
  input  logic [NUM_Q-1:0]       done_i,
  output logic                   launch_valid_o,
  output logic [ID_W-1:0]        launch_id_o,
  output logic [PTR_W-1:0]       launch_ptr_o
);
  logic [NUM_Q-1:0] elig, grant, empty, full, busy_q, en_mask;
  logic [PTR_W-1:0] head [NUM_Q];
  logic             any_gnt;
  logic [ID_W-1:0]  gnt_idx;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    assign en_mask[q]      = (EN_W'(q) < q_en_cnt_i);
    assign push_ready_o[q] = ~full[q];
    assign elig[q]         = en_mask[q] & ~empty[q] & ~busy_q[q];
    assign grant[q]        = any_gnt & (gnt_idx == ID_W'(q));

    tpd_fifo #(.DEPTH(DEPTH), .W(PTR_W)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push_valid_i[q]),
      .wdata_i (push_ptr_i[q*PTR_W +: PTR_W]),
      .pop_i   (grant[q]),
      .rdata_o (head[q]),
      .full_o  (full[q]),
      .empty_o (empty[q])
    );

    // thread slot: set on launch, cleared by done; a grant needs an idle slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        busy_q[q] <= 1'b0;
      else if (grant[q])  busy_q[q] <= 1'b1;
      else if (done_i[q]) busy_q[q] <= 1'b0;
    end
  end

  tpd_rr_arb #(.N(NUM_Q)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (elig),
    .any_o  (any_gnt),
    .idx_o  (gnt_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      launch_valid_o <= 1'b0;
      launch_id_o    <= '0;
      launch_ptr_o   <= '0;
    end else begin
      launch_valid_o <= any_gnt;
      if (any_gnt) begin
        launch_id_o  <= gnt_idx;
        launch_ptr_o <= head[gnt_idx];
      end
    end
  end
endmodule

// File: rtl/tpd_chk.sv
module tpd_chk #(
  parameter  int unsigned NUM_Q = tpd_pkg::NUM_Q_DEF,
  parameter  int unsigned DEPTH = tpd_pkg::DEPTH_DEF,
  parameter  int unsigned PTR_W = tpd_pkg::PTR_W_DEF,
  localparam int unsigned ID_W  = tpd_pkg::idx_w(NUM_Q),
  localparam int unsigned EN_W  = $clog2(NUM_Q + 1),
  localparam int unsigned CW    = $clog2(DEPTH + 2) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [EN_W-1:0]   q_en_cnt_i,
  input logic [NUM_Q-1:0]  push_valid_i,
  input logic [NUM_Q-1:0]  push_ready_o,
  input logic [NUM_Q-1:0]  done_i,
  input logic              launch_valid_o,
  input logic [ID_W-1:0]   launch_id_o
);
  logic [CW-1:0]    occ   [NUM_Q];
  logic [CW-1:0]    occ_adj [NUM_Q];
  logic [NUM_Q-1:0] out_q;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_c
    logic hit;
    assign hit        = launch_valid_o && (launch_id_o == ID_W'(q));
    assign occ_adj[q] = occ[q] - CW'(hit);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        occ[q]   <= '0;
        out_q[q] <= 1'b0;
      end else begin
        occ[q]   <= occ[q] + CW'(push_valid_i[q] & push_ready_o[q]) - CW'(hit);
        out_q[q] <= (out_q[q] | hit) & ~done_i[q];
      end
    end

    // R2: ready tracks occupancy seen at the ports
    p_ready_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_ready_o[q] == (occ_adj[q] < CW'(DEPTH)));
  end

  // R5: no relaunch of a thread that has not reported done
  p_one_outstanding_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_valid_o |-> !out_q[launch_id_o]);

  // R8: only enabled queues launch
  p_enabled_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_valid_o |-> (EN_W'(launch_id_o) < $past(q_en_cnt_i)));

  // R4: a launch always consumes an accepted pointer
  p_launch_has_ptr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_valid_o |-> (occ[launch_id_o] != '0));
endmodule

bind task_ptr_dispatch tpd_chk #(.NUM_Q(NUM_Q), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .q_en_cnt_i     (q_en_cnt_i),
  .push_valid_i   (push_valid_i),
  .push_ready_o   (push_ready_o),
  .done_i         (done_i),
  .launch_valid_o (launch_valid_o),
  .launch_id_o    (launch_id_o)
);

// File: tb/task_ptr_dispatch_test.sv
`timescale 1ns/1ps
module task_ptr_dispatch_test;
  localparam int NQ = 4;
  localparam int DP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  tb_en = 3'd4;
  logic [3:0]  tb_pv = '0;
  logic [31:0] tb_ptr [NQ];
  logic [3:0]  tb_done = '0;
  logic [127:0] ptr_flat;
  logic [3:0]  ready;
  logic        lv;
  logic [1:0]  lid;
  logic [31:0] lptr;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] m_mem [NQ][DP];
  int m_cnt [NQ], m_rd [NQ];
  bit m_busy [NQ];
  int m_last = NQ - 1;
  bit e_v;
  int e_id;
  logic [31:0] e_ptr;

  always #2.5 clk = ~clk;

  always_comb
    for (int q = 0; q < NQ; q++) ptr_flat[q*32 +: 32] = tb_ptr[q];

  task_ptr_dispatch uut (
    .clk_i(clk), .rst_ni(rst_n), .q_en_cnt_i(tb_en),
    .push_valid_i(tb_pv), .push_ptr_i(ptr_flat), .push_ready_o(ready),
    .done_i(tb_done), .launch_valid_o(lv), .launch_id_o(lid), .launch_ptr_o(lptr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // apply inputs at a negedge, advance model, check outputs at the next negedge
  task automatic step();
    int g;
    for (int q = 0; q < NQ; q++)
      chk(ready[q] == (m_cnt[q] < DP), "R2 push_ready", 32'(ready[q]), 32'(m_cnt[q] < DP));
    g = -1;
    for (int k = 1; k <= NQ; k++) begin
      int j;
      j = (m_last + k) % NQ;
      if (g < 0 && j < int'(tb_en) && m_cnt[j] > 0 && !m_busy[j]) g = j;
    end
    e_v = (g >= 0);
    if (e_v) begin
      e_id  = g;
      e_ptr = m_mem[g][m_rd[g]];
    end
    for (int q = 0; q < NQ; q++) begin
      bit can_push;
      can_push = tb_pv[q] && m_cnt[q] < DP;
      if (q == g) begin
        m_busy[q] = 1;
        m_rd[q] = (m_rd[q] + 1) % DP;
        m_cnt[q]--;
      end else if (tb_done[q]) m_busy[q] = 0;
      if (can_push) begin
        m_mem[q][(m_rd[q] + m_cnt[q]) % DP] = tb_ptr[q];
        m_cnt[q]++;
      end
    end
    if (e_v) m_last = g;
    @(negedge clk);
    chk(lv == e_v, "R4/R5/R6/R8/R9 launch_valid", 32'(lv), 32'(e_v));
    if (e_v && lv) begin
      chk(int'(lid) == e_id, "R7/R10 launch_id", 32'(lid), 32'(e_id));
      chk(lptr == e_ptr, "R3/R4 launch_ptr", lptr, e_ptr);
    end
  endtask

  task automatic idle_inputs();
    tb_pv = '0;
    tb_done = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int q = 0; q < NQ; q++) begin
      tb_ptr[q] = '0;
      m_cnt[q] = 0;
      m_rd[q] = 0;
      m_busy[q] = 0;
    end
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(lv == 1'b0, "R1 launch_valid in reset", 32'(lv), 0);
    chk(ready == 4'hf, "R1 push_ready in reset", 32'(ready), 32'hf);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lv == 1'b0, "R1 launch_valid after reset", 32'(lv), 0);
    chk(ready == 4'hf, "R1 push_ready after reset", 32'(ready), 32'hf);

    // R2/R8: fill queue 1 past depth while all queues disabled
    tb_en = 3'd0;
    for (int i = 0; i < DP + 2; i++) begin
      idle_inputs();
      tb_pv[1] = 1'b1;
      tb_ptr[1] = 32'h1000 + 32'(i);
      step();
    end
    idle_inputs();
    step();
    chk(ready[1] == 1'b0, "R2 full after 8 pushes", 32'(ready[1]), 0);
    chk(lv == 1'b0, "R8 disabled queue silent", 32'(lv), 0);
    // R8: enabling only queue 0 still keeps queue 1 quiet
    tb_en = 3'd1;
    repeat (3) step();
    // R3/R8: enable and drain in order, done after each launch
    tb_en = 3'd4;
    for (int i = 0; i < 3 * DP; i++) begin
      idle_inputs();
      tb_done[1] = lv;
      step();
    end

    // R9: stray done pulses on idle queues
    for (int i = 0; i < 4; i++) begin
      idle_inputs();
      tb_done = 4'hf;
      step();
    end

    // R7/R10: load every queue twice, no done, then release one by one
    for (int i = 0; i < 2; i++) begin
      idle_inputs();
      tb_pv = 4'hf;
      for (int q = 0; q < NQ; q++) tb_ptr[q] = 32'h2000 + 32'(q * 16 + i);
      step();
    end
    idle_inputs();
    repeat (6) step();
    for (int q = NQ - 1; q >= 0; q--) begin
      idle_inputs();
      tb_done[q] = 1'b1;
      step();
      idle_inputs();
      repeat (2) step();
    end
    idle_inputs();
    tb_done = 4'hf;
    repeat (4) step();

    // constrained random mix
    for (int c = 0; c < 4000; c++) begin
      if (c % 150 == 0) tb_en = (($urandom % 3) == 0) ? 3'($urandom % 5) : 3'd4;
      for (int q = 0; q < NQ; q++) begin
        tb_pv[q] = (($urandom % 4) == 0);
        tb_ptr[q] = $urandom;
        tb_done[q] = (($urandom % 5) == 0);
      end
      step();
    end

    // drain
    tb_en = 3'd4;
    for (int i = 0; i < 80; i++) begin
      idle_inputs();
      tb_done = 4'hf;
      step();
    end
    for (int q = 0; q < NQ; q++)
      chk(m_cnt[q] == 0 && ready[q], "R4 all pointers launched", 32'(m_cnt[q]), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule